// File: doc/BRIEF.md
# General-Purpose Pin Bank with Atomic Output Update

This block is a bank of 32 general-purpose pins that software drives through a simple memory-mapped word port. Each pin has a direction bit and an output latch bit, and the level that comes in from the pad passes through a two-stage synchronizer before software can read it. The block sends an output-enable and an output level to each pad.

Software can write the output latch as a whole word. It can also change single pins through two write-only alias addresses. One alias sets every latch bit whose mask bit is 1, and the other clears every latch bit whose mask bit is 1. With these aliases, driver code that handles one pin never has to read, modify and write back a word that another context might change in between. A fixed revision word lets software identify the block.

The request port accepts one access per cycle. Read data comes back from a register one cycle later, together with a valid strobe.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the direction register reads 0xFFFFFFFF (all pins inputs) and the output latch reads 0. pad_oe_o is 0 and pad_out_o is 0.
- R2: The direction register is at byte offset 0x134 and can be read and written. A 1 in bit n makes pin n an input, and a 0 makes it a driven output, so pad_oe_o[n] is the inverse of bit n. The register changes only when it is written.
- R3: The output latch is at offset 0x13C and can be read and written. pad_out_o follows the latch. The latch changes only on writes to 0x13C, 0x194 or 0x190.
- R4: Writing a mask to offset 0x194 sets each latch bit whose mask bit is 1 and leaves the other bits unchanged. The new value is visible on pad_out_o after the write edge.
- R5: Writing a mask to offset 0x190 clears each latch bit whose mask bit is 1 and leaves the other bits unchanged.
- R6: Reads of offsets 0x194 and 0x190 return 0.
- R7: Offset 0x000 reads the constant 0x50600801. A write to it has no effect.
- R8: Offset 0x138 returns the pad input levels after a two-flop synchronizer. A level held on pad_in_i for three clock edges is guaranteed to be visible to a read issued on the next edge. A write to 0x138 has no effect.
- R9: A read of any unmapped offset returns 0. A write to an unmapped offset changes neither the direction register nor the output latch.
- R10: A read request captured at a clock edge raises rd_valid_o for exactly the following cycle, with the data on rd_data_o. Writes never raise rd_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data or mask |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| pad_in_i | input | 32 | Asynchronous pad input levels |
| pad_oe_o | output | 32 | Per-pin output enable, 1 = drive |
| pad_out_o | output | 32 | Per-pin output level |

## Verification
The assertions assume that req_write_i, req_addr_i and req_wdata_i are settled whenever req_valid_i is high, and that only one access is presented per edge. They also assume that pad_in_i can change at any time. The bench drives every bus input just after a rising edge and holds it for a whole cycle. It changes pad_in_i only while no read of the input register is pending, and it waits out the synchronizer delay before it reads that register.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] OFS_REV  = 12'h000;
  localparam logic [AW-1:0] OFS_DIR  = 12'h134;
  localparam logic [AW-1:0] OFS_PIN  = 12'h138;
  localparam logic [AW-1:0] OFS_LAT  = 12'h13C;
  localparam logic [AW-1:0] OFS_CLR  = 12'h190;
  localparam logic [AW-1:0] OFS_SET  = 12'h194;
  localparam logic [DW-1:0] REV_WORD = 32'h5060_0801;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_REV, SEL_DIR, SEL_PIN, SEL_LAT, SEL_ALIAS
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [AW-1:0] a);
    case (a)
      OFS_REV:          return SEL_REV;
      OFS_DIR:          return SEL_DIR;
      OFS_PIN:          return SEL_PIN;
      OFS_LAT:          return SEL_LAT;
      OFS_CLR, OFS_SET: return SEL_ALIAS;
      default:          return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_dir_i,
  input  logic         wr_lat_i,
  input  logic [W-1:0] set_mask_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] lat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_o <= '1;
    else if (wr_dir_i) dir_o <= wdata_i;
  end

  // clear applied after set: clear wins on a shared bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_o <= '0;
    else if (wr_lat_i) lat_o <= wdata_i;
    else lat_o <= (lat_o | set_mask_i) & ~clr_mask_i;
  end
endmodule

// File: rtl/gpb_rdmux.sv
module gpb_rdmux
  import gpb_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  reg_sel_e      sel_i,
  input  logic [W-1:0]  dir_i,
  input  logic [W-1:0]  lat_i,
  input  logic [W-1:0]  pin_i,
  output logic [DW-1:0] data_o
);
  always_comb begin
    data_o = '0;
    case (sel_i)
      SEL_REV: data_o = REV_WORD;
      SEL_DIR: data_o[W-1:0] = dir_i;
      SEL_PIN: data_o[W-1:0] = pin_i;
      SEL_LAT: data_o[W-1:0] = lat_i;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  input  logic [NPINS-1:0] pad_in_i,
  output logic [NPINS-1:0] pad_oe_o,
  output logic [NPINS-1:0] pad_out_o
);
  reg_sel_e         sel;
  logic             wr, rd;
  logic [NPINS-1:0] dir, lat, pin, set_mask, clr_mask, wdata;
  logic [DW-1:0]    rd_word;

  assign sel      = decode(req_addr_i);
  assign wr       = req_valid_i & req_write_i;
  assign rd       = req_valid_i & ~req_write_i;
  assign wdata    = req_wdata_i[NPINS-1:0];
  assign set_mask = (wr && req_addr_i == OFS_SET) ? wdata : '0;
  assign clr_mask = (wr && req_addr_i == OFS_CLR) ? wdata : '0;

  gpb_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pin)
  );

  gpb_regs #(.W(NPINS)) u_regs (
    .clk_i, .rst_ni,
    .wr_dir_i  (wr && sel == SEL_DIR),
    .wr_lat_i  (wr && sel == SEL_LAT),
    .set_mask_i(set_mask),
    .clr_mask_i(clr_mask),
    .wdata_i   (wdata),
    .dir_o     (dir),
    .lat_o     (lat)
  );

  gpb_rdmux #(.W(NPINS)) u_rdmux (
    .sel_i(sel), .dir_i(dir), .lat_i(lat), .pin_i(pin), .data_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd;
      rd_data_o  <= rd ? rd_word : '0;
    end
  end

  assign pad_oe_o  = ~dir;
  assign pad_out_o = lat;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic [AW-1:0]    req_addr_i,
  input logic [DW-1:0]    req_wdata_i,
  input logic             rd_valid_o,
  input logic [DW-1:0]    rd_data_o,
  input logic [NPINS-1:0] pad_oe_o,
  input logic [NPINS-1:0] pad_out_o
);
  logic wr, rd;
  assign wr = req_valid_i & req_write_i;
  assign rd = req_valid_i & ~req_write_i;

  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && req_addr_i == OFS_DIR) |=> $stable(pad_oe_o)); // R2
  AST_LAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (req_addr_i == OFS_LAT || req_addr_i == OFS_SET || req_addr_i == OFS_CLR))
    |=> $stable(pad_out_o)); // R3
  AST_SET_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == OFS_SET)
    |=> pad_out_o == ($past(pad_out_o) | $past(req_wdata_i[NPINS-1:0]))); // R4
  AST_CLR_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == OFS_CLR)
    |=> pad_out_o == ($past(pad_out_o) & ~$past(req_wdata_i[NPINS-1:0]))); // R5
  AST_ALIAS_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (req_addr_i == OFS_SET || req_addr_i == OFS_CLR)) |=> rd_data_o == '0); // R6
  AST_REV_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && req_addr_i == OFS_REV) |=> rd_data_o == REV_WORD); // R7
  AST_RD_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rd_valid_o); // R10
  AST_NO_SPURIOUS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rd_valid_o); // R10
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
  .rd_valid_o, .rd_data_o, .pad_oe_o, .pad_out_o
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, pad_in = '0;
  logic        rd_valid;
  logic [31:0] rd_data, pad_oe, pad_out;

  int n_vec = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  gpio_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .pad_in_i(pad_in), .pad_oe_o(pad_oe), .pad_out_o(pad_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // monitor: pop expected read data as it appears
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
      begin
        repeat (3) @(posedge clk); #1;
        check("R1 pad_oe reset", pad_oe, 32'h0);
        check("R1 pad_out reset", pad_out, 32'h0);
        rst_n = 1;
        bus_read(12'h134, 32'hFFFF_FFFF, "R1 dir reset");
        bus_read(12'h13C, 32'h0, "R1 latch reset");
        bus_read(12'h000, 32'h5060_0801, "R7 revision");
        bus_write(12'h134, 32'h0000_FF0F);
        check("R2 pad_oe inverse", pad_oe, 32'hFFFF_00F0);
        bus_read(12'h134, 32'h0000_FF0F, "R2 dir readback");
        bus_write(12'h13C, 32'hA5A5_0000);
        check("R3 pad_out direct", pad_out, 32'hA5A5_0000);
        bus_read(12'h13C, 32'hA5A5_0000, "R3 latch readback");
        bus_write(12'h194, 32'h0000_0011);
        check("R4 set alias", pad_out, 32'hA5A5_0011);
        bus_write(12'h194, 32'h8000_0000);
        check("R4 set alias top bit", pad_out, 32'hA5A5_0011);
        bus_write(12'h190, 32'h2500_0001);
        check("R5 clear alias", pad_out, 32'h80A5_0010);
        bus_write(12'h190, 32'h0);
        check("R5 clear zero mask", pad_out, 32'h80A5_0010);
        bus_read(12'h194, 32'h0, "R6 set alias read");
        bus_read(12'h190, 32'h0, "R6 clear alias read");
        bus_write(12'h000, 32'h1234_5678);
        bus_read(12'h000, 32'h5060_0801, "R7 revision after write");
        @(posedge clk); #1 pad_in = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        bus_read(12'h138, 32'hDEAD_BEEF, "R8 input sample");
        bus_write(12'h138, 32'h0);
        bus_read(12'h138, 32'hDEAD_BEEF, "R8 input write ignored");
        @(posedge clk); #1 pad_in = 32'h0F0F_0001;
        repeat (3) @(posedge clk);
        bus_read(12'h138, 32'h0F0F_0001, "R8 input second pattern");
        bus_write(12'h200, 32'hFFFF_FFFF);
        bus_write(12'h135, 32'hFFFF_FFFF);
        check("R9 unmapped write pad_out", pad_out, 32'h80A5_0010);
        check("R9 unmapped write pad_oe", pad_oe, 32'hFFFF_00F0);
        bus_read(12'h200, 32'h0, "R9 unmapped read");
        bus_read(12'h134, 32'h0000_FF0F, "R9 dir untouched");
        bus_read(12'h13C, 32'h80A5_0010, "R9 latch untouched");
        repeat (4) @(posedge clk);
        check("R10 all reads returned", exp_q.size(), 32'h0);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule